// File: doc/BRIEF.md
# Fuzzy-Mean Defuzzifier with Bit-Serial Divider

This block turns a stream of fired rules into one crisp output value. Each rule arrives as a pair: an activation degree and a consequent value, both unsigned fractions of the unit interval. A first stage keeps two running sums over the rules of one inference frame. One sum adds up the degrees. The other adds up each degree multiplied by its consequent. The last rule of a frame is flagged, and on that rule both finished sums are handed to a second stage.

The second stage divides the weighted sum by the degree sum. It uses a non-restoring algorithm that produces one quotient bit per clock and needs only add, subtract and shift. Because the two stages are separate, the next frame can be accumulated while the previous one is still being divided.

When the caller knows that the degrees of a frame add up to exactly one, it can raise a skip flag together with the last rule. The division is then skipped and the scaled weighted sum is output one clock later.

Top module: `fuzzy_mean_defuzz`

## Requirements
- R1: After reset, `crisp_vld_o` is 0 and `crisp_o` is 0.
- R2: With the skip flag low and a nonzero degree sum D, the result is floor(N·2^OUT_W / (D·2^CONS_W)), where N is the sum of degree × consequent. Degrees and consequents are raw unsigned codes.
- R3: With the skip flag low and a nonzero degree sum, the last rule is sampled at clock edge k. `crisp_vld_o` is then high for exactly one cycle, the cycle that follows edge k+OUT_W−1. No other valid pulse is produced.
- R4: With `skip_div_i` high on the last rule, the result is min(floor(N·2^OUT_W / 2^(DEG_W+CONS_W)), 2^OUT_W−1). It is valid in the cycle after the edge that samples the last rule.
- R5: With the skip flag low and a degree sum of zero, the result is 0. It is valid in the cycle after the edge that samples the last rule.
- R6: A frame holds 1 to MAX_RULES rules. Both sums restart after every last rule, so no frame's result depends on an earlier frame.
- R7: A new frame's rules may be accepted while a division is running. Last rules may be spaced as close as OUT_W clock edges apart, and every result stays correct.
- R8: `crisp_o` keeps its value in every cycle in which `crisp_vld_o` is low.
- R9: Cycles with `rule_vld_i` low are ignored, whatever `rule_last_i`, `rule_deg_i`, `rule_cons_i` and `skip_div_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rule_vld_i | input | 1 | A rule pair is present this cycle |
| rule_last_i | input | 1 | This rule closes the frame |
| rule_deg_i | input | DEG_W | Activation degree, unit-interval fraction |
| rule_cons_i | input | CONS_W | Consequent value, unit-interval fraction |
| skip_div_i | input | 1 | Skip the division for this frame; sampled with the last rule |
| crisp_vld_o | output | 1 | One-cycle strobe: a new crisp result is present |
| crisp_o | output | OUT_W | Crisp output, truncated unit-interval fraction |

## Verification
Two things can happen in the same clock cycle: the divider works out the final quotient bits of one frame, and the accumulator takes in the opening rules of the next frame. The overlap test provokes this by placing each new frame so that its last rule lands exactly OUT_W edges after the previous one, with random frame lengths and a mix of divided and skipped frames. A bypass result can therefore land on the cycle right after a divided result. Every result is judged on its value and on the exact cycle it appears, against sums and a truncated quotient that the bench computes itself. Any extra or missing strobe is counted as a failure.

// File: rtl/fmd_pkg.sv
`timescale 1ns/1ps
package fmd_pkg;

  // action taken by the division stage when a finished frame arrives
  typedef enum logic [1:0] {
    LD_NONE,
    LD_BYPASS,
    LD_ZERO,
    LD_DIV
  } fmd_ld_e;

  function automatic int fmd_cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fmd_accum.sv
`timescale 1ns/1ps
module fmd_accum #(
  parameter int DEG_W     = 8,
  parameter int CONS_W    = 8,
  parameter int MAX_RULES = 4,
  parameter int NUM_W     = 19,
  parameter int DEN_W     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [DEG_W-1:0]  deg_i,
  input  logic [CONS_W-1:0] cons_i,
  input  logic              byp_i,
  output logic              tot_vld_o,
  output logic              tot_byp_o,
  output logic [NUM_W-1:0]  tot_num_o,
  output logic [DEN_W-1:0]  tot_den_o
);
  localparam int PROD_W = DEG_W + CONS_W;
  localparam int RC_W   = fmd_pkg::fmd_cnt_w(MAX_RULES);

  logic [PROD_W-1:0] prod;
  logic [NUM_W-1:0]  acc_num_q, base_num;
  logic [DEN_W-1:0]  acc_den_q, base_den;
  logic              fresh_q;
  logic [RC_W-1:0]   rule_cnt_q;

  assign prod     = PROD_W'(deg_i) * PROD_W'(cons_i);
  assign base_num = fresh_q ? '0 : acc_num_q;
  assign base_den = fresh_q ? '0 : acc_den_q;

  assign tot_num_o = base_num + NUM_W'(prod);
  assign tot_den_o = base_den + DEN_W'(deg_i);
  assign tot_vld_o = in_valid_i & in_last_i;
  assign tot_byp_o = byp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_num_q  <= '0;
      acc_den_q  <= '0;
      fresh_q    <= 1'b1;
      rule_cnt_q <= '0;
    end else if (in_valid_i) begin
      if (in_last_i) begin
        fresh_q    <= 1'b1;
        rule_cnt_q <= '0;
      end else begin
        acc_num_q  <= tot_num_o;
        acc_den_q  <= tot_den_o;
        fresh_q    <= 1'b0;
        rule_cnt_q <= rule_cnt_q + 1'b1;
      end
    end
  end

  // R6
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (rule_cnt_q < RC_W'(MAX_RULES)));

endmodule

// File: rtl/fmd_serial_div.sv
`timescale 1ns/1ps
module fmd_serial_div #(
  parameter int NUM_W  = 19,
  parameter int DEN_W  = 11,
  parameter int CONS_W = 8,
  parameter int PROD_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             byp_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             res_vld_o,
  output logic [OUT_W-1:0] res_o
);
  import fmd_pkg::*;

  localparam int R_W   = NUM_W + 2;
  localparam int CNT_W = fmd_cnt_w(OUT_W);
  localparam int BW    = NUM_W + OUT_W;

  fmd_ld_e                kind;
  logic signed [R_W-1:0]  rem_q, dsor_q, rem_nx, num_ext, dsor_ld, r_first;
  logic [OUT_W-1:0]       q_q, q_nx, byp_sat;
  logic [CNT_W-1:0]       cnt_q;
  logic                   busy_q;
  logic [BW-1:0]          byp_full;

  always_comb begin
    if (!ld_i)             kind = LD_NONE;
    else if (byp_i)        kind = LD_BYPASS;
    else if (den_i == '0)  kind = LD_ZERO;
    else                   kind = LD_DIV;
  end

  assign num_ext  = R_W'(num_i);
  assign dsor_ld  = R_W'({den_i, {CONS_W{1'b0}}});
  assign r_first  = (num_ext <<< 1) - dsor_ld;

  // non-restoring step: sign of partial remainder picks add or subtract
  assign rem_nx = rem_q[R_W-1] ? ((rem_q <<< 1) + dsor_q) : ((rem_q <<< 1) - dsor_q);
  assign q_nx   = OUT_W'({q_q, ~rem_nx[R_W-1]});

  assign byp_full = (BW'(num_i) << OUT_W) >> PROD_W;
  assign byp_sat  = (|byp_full[BW-1:OUT_W]) ? '1 : byp_full[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      dsor_q    <= '0;
      q_q       <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      res_vld_o <= 1'b0;
      res_o     <= '0;
    end else begin
      unique case (kind)
        LD_BYPASS: begin
          res_o     <= byp_sat;
          res_vld_o <= 1'b1;
          busy_q    <= 1'b0;
        end
        LD_ZERO: begin
          res_o     <= '0;
          res_vld_o <= 1'b1;
          busy_q    <= 1'b0;
        end
        LD_DIV: begin
          rem_q     <= r_first;
          dsor_q    <= dsor_ld;
          q_q       <= OUT_W'(~r_first[R_W-1]);
          cnt_q     <= CNT_W'(OUT_W - 1);
          busy_q    <= 1'b1;
          res_vld_o <= 1'b0;
        end
        default: begin
          if (busy_q) begin
            rem_q <= rem_nx;
            q_q   <= q_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              busy_q    <= 1'b0;
              res_o     <= q_nx;
              res_vld_o <= 1'b1;
            end else begin
              res_vld_o <= 1'b0;
            end
          end else begin
            res_vld_o <= 1'b0;
          end
        end
      endcase
    end
  end

  // R7
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !busy_q);

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((rem_q >= -dsor_q) && (rem_q < dsor_q)));

  // R5
  zero_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !byp_i && (den_i == '0)) |=> (res_vld_o && (res_o == '0)));

  // R4
  byp_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && byp_i) |=> res_vld_o);

  // R3
  div_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !byp_i && (den_i != '0)) |=> !res_vld_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o));

endmodule

// File: rtl/fuzzy_mean_defuzz.sv
`timescale 1ns/1ps
module fuzzy_mean_defuzz #(
  parameter int DEG_W     = 8,
  parameter int CONS_W    = 8,
  parameter int OUT_W     = 8,
  parameter int MAX_RULES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rule_vld_i,
  input  logic              rule_last_i,
  input  logic [DEG_W-1:0]  rule_deg_i,
  input  logic [CONS_W-1:0] rule_cons_i,
  input  logic              skip_div_i,
  output logic              crisp_vld_o,
  output logic [OUT_W-1:0]  crisp_o
);
  localparam int RC_W   = fmd_pkg::fmd_cnt_w(MAX_RULES);
  localparam int PROD_W = DEG_W + CONS_W;
  localparam int NUM_W  = PROD_W + RC_W;
  localparam int DEN_W  = DEG_W + RC_W;

  logic             tot_vld, tot_byp;
  logic [NUM_W-1:0] tot_num;
  logic [DEN_W-1:0] tot_den;

  fmd_accum #(
    .DEG_W(DEG_W), .CONS_W(CONS_W), .MAX_RULES(MAX_RULES),
    .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) i_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rule_vld_i),
    .in_last_i  (rule_last_i),
    .deg_i      (rule_deg_i),
    .cons_i     (rule_cons_i),
    .byp_i      (skip_div_i),
    .tot_vld_o  (tot_vld),
    .tot_byp_o  (tot_byp),
    .tot_num_o  (tot_num),
    .tot_den_o  (tot_den)
  );

  fmd_serial_div #(
    .NUM_W(NUM_W), .DEN_W(DEN_W), .CONS_W(CONS_W),
    .PROD_W(PROD_W), .OUT_W(OUT_W)
  ) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (tot_vld),
    .byp_i     (tot_byp),
    .num_i     (tot_num),
    .den_i     (tot_den),
    .res_vld_o (crisp_vld_o),
    .res_o     (crisp_o)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!crisp_vld_o && (crisp_o == '0)));

endmodule

// File: tb/test_fuzzy_mean_defuzz.sv
`timescale 1ns/1ps
module test_fuzzy_mean_defuzz;
  localparam int DEG_W = 8, CONS_W = 8, OUT_W = 8, MAX_RULES = 4;
  localparam longint OMAX = (64'd1 << OUT_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rule_vld_i = 1'b0, rule_last_i = 1'b0, skip_div_i = 1'b0;
  logic [DEG_W-1:0]  rule_deg_i = '0;
  logic [CONS_W-1:0] rule_cons_i = '0;
  logic              crisp_vld_o;
  logic [OUT_W-1:0]  crisp_o;

  fuzzy_mean_defuzz #(.DEG_W(DEG_W), .CONS_W(CONS_W), .OUT_W(OUT_W), .MAX_RULES(MAX_RULES))
    i_fuzzy_mean_defuzz (.*);

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  longint acc_num = 0, acc_den = 0;
  longint exp_v[$]; int exp_t[$]; string exp_r[$];
  longint obs_v[$]; int obs_t[$];
  longint last_res = 0;

  always @(negedge clk_i)
    if (rst_ni && crisp_vld_o) begin
      obs_v.push_back(longint'(crisp_o));
      obs_t.push_back(cyc);
    end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic rule(int d, int c, bit last, bit byp, string req);
    longint e;
    int t;
    @(negedge clk_i);
    rule_vld_i  = 1'b1;
    rule_last_i = last;
    rule_deg_i  = d[DEG_W-1:0];
    rule_cons_i = c[CONS_W-1:0];
    skip_div_i  = byp;
    acc_num += longint'(d) * longint'(c);
    acc_den += longint'(d);
    if (last) begin
      if (byp) begin
        e = (acc_num << OUT_W) >> (DEG_W + CONS_W);
        if (e > OMAX) e = OMAX;
        t = cyc + 1;
      end else if (acc_den == 0) begin
        e = 0;
        t = cyc + 1;
      end else begin
        e = (acc_num << OUT_W) / (acc_den << CONS_W);
        t = cyc + OUT_W;
      end
      exp_v.push_back(e); exp_t.push_back(t); exp_r.push_back(req);
      acc_num = 0;
      acc_den = 0;
    end
  endtask

  task automatic idle(int n, bit junk);
    repeat (n) begin
      @(negedge clk_i);
      rule_vld_i = 1'b0;
      rule_last_i = junk;
      skip_div_i = junk ? 1'($urandom) : 1'b0;
      if (junk) begin
        rule_deg_i  = DEG_W'($urandom);
        rule_cons_i = CONS_W'($urandom);
      end
    end
  endtask

  task automatic frame(int n, bit byp, string req);
    for (int i = 0; i < n; i++)
      rule(int'($urandom % 256), int'($urandom % 256), i == n - 1, byp, req);
  endtask

  task automatic drain();
    string r;
    idle(OUT_W + 2, 0);
    while (exp_v.size() > 0) begin
      r = exp_r.pop_front();
      if (obs_v.size() == 0) begin
        check(0, r, "missing result", -1, exp_v.pop_front());
        void'(exp_t.pop_front());
      end else begin
        last_res = obs_v[0];
        check(obs_v[0] == exp_v[0], r, "value", obs_v.pop_front(), exp_v.pop_front());
        check(obs_t[0] == exp_t[0], r, "valid cycle", obs_t.pop_front(), exp_t.pop_front());
      end
    end
    while (obs_v.size() > 0) begin
      void'(obs_t.pop_front());
      check(0, "R3", "spurious valid", obs_v.pop_front(), -1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(crisp_vld_o == 1'b0, "R1", "valid after reset", crisp_vld_o, 0);
    check(crisp_o == '0, "R1", "output after reset", crisp_o, 0);
  endtask

  task automatic t_single();
    rule(200, 100, 1, 0, "R2");       // 100
    idle(OUT_W, 0);
    rule(255, 255, 1, 0, "R2");       // top code 255
    idle(OUT_W, 0);
    rule(3, 7, 0, 0, "R2");
    rule(1, 250, 1, 0, "R2");
    drain();
  endtask

  task automatic t_random_div();
    for (int k = 0; k < 24; k++) begin
      frame(1 + int'($urandom % MAX_RULES), 0, "R6");
      idle(OUT_W, 0);
    end
    drain();
  endtask

  task automatic t_bypass();
    int d0;
    rule(64, 10, 0, 1, "R4");
    rule(192, 250, 1, 1, "R4");       // 48640>>8 = 190
    idle(2, 0);
    rule(255, 255, 0, 1, "R4");
    rule(255, 255, 1, 1, "R4");       // saturates at 255
    idle(2, 0);
    for (int k = 0; k < 8; k++) begin
      d0 = 1 + int'($urandom % 255);
      rule(d0, int'($urandom % 256), 0, 1, "R4");
      rule(256 - d0, int'($urandom % 256), 1, 1, "R4");
      idle(1, 0);
    end
    drain();
  endtask

  task automatic t_zero();
    rule(0, 200, 0, 0, "R5");
    rule(0, 17, 0, 0, "R5");
    rule(0, 255, 1, 0, "R5");
    drain();
  endtask

  task automatic t_gaps();
    rule(90, 40, 0, 0, "R9");
    idle(3, 1);
    rule(30, 220, 0, 0, "R9");
    idle(2, 1);
    rule(120, 5, 1, 0, "R9");
    idle(OUT_W, 1);
    rule(128, 60, 0, 1, "R9");
    idle(4, 1);
    rule(128, 180, 1, 1, "R9");
    drain();
  endtask

  task automatic t_overlap();
    int n;
    frame(MAX_RULES, 0, "R7");
    for (int k = 0; k < 16; k++) begin
      n = 1 + int'($urandom % MAX_RULES);
      idle(OUT_W - n, 0);
      frame(n, (k % 3) == 2, "R7");
    end
    drain();
  endtask

  task automatic t_hold();
    rule(77, 33, 1, 0, "R8");
    drain();
    for (int k = 0; k < 6; k++) begin
      idle(1, 1);
      check(crisp_vld_o == 1'b0, "R8", "valid while idle", crisp_vld_o, 0);
      check(longint'(crisp_o) == last_res, "R8", "held output", crisp_o, last_res);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_random_div();
    t_bypass();
    t_zero();
    t_gaps();
    t_overlap();
    t_hold();
    done = 1;
    summary();
    $finish;
  end

endmodule